// File: doc/BRIEF.md
# Serial Register Bank with Broadcast

This block is the control-register slave of a multi-channel video front end. A host shifts frames over a three-wire serial link: an enable, a clock and a data line. The block decodes a 6-bit register address and keeps the settings the datapath needs: an 8-bit offset code and a 9-bit gain code for each of three colour channels, and a power-down register. The settings leave the block as parallel buses. Channel 0 is red, channel 1 is green and channel 2 is blue.

Each gain code is split across two registers. One holds bits 8:1 and another holds bit 0 only. The datapath sees the joined code. Three write-only broadcast addresses load the same value into all three channel copies with a single frame. This is how a host gives every colour the same setting at once.

The whole block runs on one system clock. The serial enable, clock and data pins are registered into that clock, and the serial clock is used only as a sampled signal. A read frame returns a register's contents on a serial data output.

Top module: `sreg_serial_bank`

## Requirements
- R1: After reset, every offset register holds 80h and every gain MSB register holds 0Ch. Every gain LSB is 0 and the power-down register is 0. Each gain output therefore reads 018h.
- R2: A write to 20h, 21h or 22h loads the offset of channel 0, 1 or 2 respectively. The other channels are left unchanged.
- R3: A write to 23h loads the written byte into all three offset registers.
- R4: A channel's gain output is {MSB register, LSB bit}. Writes to 28h/29h/2Ah load bits 8:1 of channel 0/1/2. Writes to 24h/25h/26h load only bit 0, taken from data bit 0.
- R5: A write to 27h loads data bit 0 into all three gain LSBs. A write to 2Bh loads the byte into all three gain MSB registers.
- R6: Address 07h is the power-down register. Data bits 6:0 drive pd_o[6:0]. Bit 7 is not stored and reads back as 0.
- R7: A frame is 15 bits, sent MSB first: a direction bit (0 = write, 1 = read), then a 6-bit address, then 8 data bits. Each bit is sampled on a rising edge of sck_i while sen_i is high. A write takes effect when sen_i falls with exactly 15 bits received.
- R8: A frame that ends with fewer or more than 15 bits changes no register. Rising edges of sck_i while sen_i is low are ignored.
- R9: In a read frame, the addressed register is shifted out on sdo_o MSB first. The first data bit is present after the 7th rising edge, and the next one after each later edge. sdo_o is 0 outside the data phase of a read, and a read changes no register.
- R10: The broadcast addresses 23h, 27h and 2Bh read back as 00h, as does any unmapped address. Reserved bits of the gain LSB registers read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sen_i | input | 1 | Serial enable; frame window while high |
| sck_i | input | 1 | Serial clock, sampled by clk_i |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial read-back data |
| ofs_o | output | 24 | Offset codes, channel 0 in bits 7:0 |
| gain_o | output | 27 | 9-bit gain codes, channel 0 in bits 8:0 |
| pd_o | output | 7 | Power-down enables |

## Verification
The bench goes after broadcast fan-out and per-channel isolation. A decoder that compared too few address bits would spill a single-channel write into a neighbour, or would miss one copy on a broadcast. It also checks that LSB writes leave the MSB half of the gain untouched. A design that stored the whole byte there would corrupt bits 8:1 or expose reserved bits on read-back.

Frames one bit short and one bit long are sent, along with clock pulses while the enable is low. A design that committed on any enable edge would take in garbage. The reads of broadcast and unmapped addresses would expose a decoder that aliases write-only locations onto stored registers.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int GAIN_W     = DATA_W + 1;
  localparam int PD_W       = 7;
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] A_PWR  = 6'h07;
  localparam logic [ADDR_W-1:0] A_OFS  = 6'h20;
  localparam logic [ADDR_W-1:0] A_GLSB = 6'h24;
  localparam logic [ADDR_W-1:0] A_GMSB = 6'h28;

  localparam logic [DATA_W-1:0] OFS_RST  = 8'h80;
  localparam logic [DATA_W-1:0] GMSB_RST = 8'h0C;
endpackage

// File: rtl/sreg_frame_rx.sv
module sreg_frame_rx
  import sreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sen_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              sdo_o
);
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic sck_q, sck_q2, sen_q, sen_q2, sdi_q;
  logic sck_rise, sen_rise, sen_fall;
  logic [FRAME_BITS-1:0] in_sr;
  logic [DATA_W-1:0]     out_sr;
  logic [CNT_W-1:0]      cnt;
  logic                  rd_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0; sck_q2 <= 1'b0;
      sen_q <= 1'b0; sen_q2 <= 1'b0;
      sdi_q <= 1'b0;
    end else begin
      sck_q <= sck_i; sck_q2 <= sck_q;
      sen_q <= sen_i; sen_q2 <= sen_q;
      sdi_q <= sdi_i;
    end
  end

  assign sck_rise = sck_q & ~sck_q2;
  assign sen_rise = sen_q & ~sen_q2;
  assign sen_fall = ~sen_q & sen_q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sr  <= '0;
      out_sr <= '0;
      cnt    <= '0;
      rd_act <= 1'b0;
    end else if (sen_rise || sen_fall) begin
      cnt    <= '0;
      rd_act <= 1'b0;
    end else if (sck_rise && sen_q) begin
      in_sr <= {in_sr[FRAME_BITS-2:0], sdi_q};
      if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(ADDR_W)) begin
        // last address bit is arriving now: latch direction and read data
        rd_act <= in_sr[ADDR_W-1];
        out_sr <= rdata_i;
      end else begin
        out_sr <= {out_sr[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign raddr_o = {in_sr[ADDR_W-2:0], sdi_q};
  assign wr_o    = sen_fall && (cnt == CNT_W'(FRAME_BITS)) && !in_sr[FRAME_BITS-1];
  assign waddr_o = in_sr[DATA_W +: ADDR_W];
  assign wdata_o = in_sr[DATA_W-1:0];
  assign sdo_o   = rd_act & out_sr[DATA_W-1];
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [NUM_CH*DATA_W-1:0] ofs_o,
  output logic [NUM_CH*GAIN_W-1:0] gain_o,
  output logic [PD_W-1:0]          pd_o
);
  localparam logic [ADDR_W-1:0] A_OFS_ALL  = A_OFS  + ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] A_GLSB_ALL = A_GLSB + ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] A_GMSB_ALL = A_GMSB + ADDR_W'(NUM_CH);

  logic [DATA_W-1:0] rd_ch [NUM_CH];
  logic [PD_W-1:0]   pd_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_O = A_OFS  + ADDR_W'(ch);
    localparam logic [ADDR_W-1:0] A_L = A_GLSB + ADDR_W'(ch);
    localparam logic [ADDR_W-1:0] A_M = A_GMSB + ADDR_W'(ch);

    logic [DATA_W-1:0] ofs_q, msb_q;
    logic              lsb_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ofs_q <= OFS_RST;
        msb_q <= GMSB_RST;
        lsb_q <= 1'b0;
      end else if (wr_i) begin
        if (waddr_i == A_O || waddr_i == A_OFS_ALL)  ofs_q <= wdata_i;
        if (waddr_i == A_M || waddr_i == A_GMSB_ALL) msb_q <= wdata_i;
        if (waddr_i == A_L || waddr_i == A_GLSB_ALL) lsb_q <= wdata_i[0];
      end
    end

    always_comb begin
      rd_ch[ch] = '0;
      if (raddr_i == A_O)      rd_ch[ch] = ofs_q;
      else if (raddr_i == A_M) rd_ch[ch] = msb_q;
      else if (raddr_i == A_L) rd_ch[ch] = {{(DATA_W-1){1'b0}}, lsb_q};
    end

    assign ofs_o[ch*DATA_W +: DATA_W]  = ofs_q;
    assign gain_o[ch*GAIN_W +: GAIN_W] = {msb_q, lsb_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pd_q <= '0;
    else if (wr_i && waddr_i == A_PWR) pd_q <= wdata_i[PD_W-1:0];
  end

  always_comb begin
    rdata_o = (raddr_i == A_PWR) ? DATA_W'(pd_q) : '0;
    for (int i = 0; i < NUM_CH; i++) rdata_o = rdata_o | rd_ch[i];
  end

  assign pd_o = pd_q;
endmodule

// File: rtl/sreg_serial_bank.sv
module sreg_serial_bank
  import sreg_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sen_i,
  input  logic                     sck_i,
  input  logic                     sdi_i,
  output logic                     sdo_o,
  output logic [NUM_CH*DATA_W-1:0] ofs_o,
  output logic [NUM_CH*GAIN_W-1:0] gain_o,
  output logic [PD_W-1:0]          pd_o
);
  logic              wr_w;
  logic [ADDR_W-1:0] waddr_w, raddr_w;
  logic [DATA_W-1:0] wdata_w, rdata_w;

  sreg_frame_rx u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sen_i   (sen_i),
    .sck_i   (sck_i),
    .sdi_i   (sdi_i),
    .rdata_i (rdata_w),
    .raddr_o (raddr_w),
    .wr_o    (wr_w),
    .waddr_o (waddr_w),
    .wdata_o (wdata_w),
    .sdo_o   (sdo_o)
  );

  sreg_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_w),
    .waddr_i (waddr_w),
    .wdata_i (wdata_w),
    .raddr_i (raddr_w),
    .rdata_o (rdata_w),
    .ofs_o   (ofs_o),
    .gain_o  (gain_o),
    .pd_o    (pd_o)
  );
endmodule

// File: rtl/sreg_serial_chk.sv
module sreg_serial_chk
  import sreg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              sdo_i,
  input logic [23:0]       ofs_i,
  input logic [26:0]       gain_i,
  input logic [PD_W-1:0]   pd_i
);
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(ofs_i) && $stable(gain_i) && $stable(pd_i))); // R8

  AST_SDO_QUIET_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !sdo_i); // R9

  AST_SINGLE_OFS_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && waddr_i == 6'h20) |=> ($stable(ofs_i[23:8]) && ofs_i[7:0] == $past(wdata_i))); // R2

  AST_BCAST_OFS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && waddr_i == 6'h23) |=> (ofs_i[7:0] == $past(wdata_i) &&
      ofs_i[15:8] == $past(wdata_i) && ofs_i[23:16] == $past(wdata_i))); // R3

  AST_LSB_KEEPS_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && waddr_i == 6'h24) |=> ($stable(gain_i[8:1]) && gain_i[0] == $past(wdata_i[0]))); // R4

  AST_BCAST_MSB_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && waddr_i == 6'h2B) |=> (gain_i[8:1] == $past(wdata_i) &&
      gain_i[17:10] == $past(wdata_i) && gain_i[26:19] == $past(wdata_i))); // R5
endmodule

bind sreg_serial_bank sreg_serial_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_w),
  .waddr_i (waddr_w),
  .wdata_i (wdata_w),
  .sdo_i   (sdo_o),
  .ofs_i   (ofs_o),
  .gain_i  (gain_o),
  .pd_i    (pd_o)
);

// File: tb/tb_sreg_serial_bank.sv
module tb_sreg_serial_bank;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sen = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [23:0] ofs;
  logic [26:0] gain;
  logic [6:0]  pd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_ofs [3];
  logic [7:0] m_msb [3];
  logic       m_lsb [3];
  logic [6:0] m_pd;

  int         pend_cnt = 0;
  logic [5:0] pend_a;
  logic [7:0] pend_d;

  always #(CLK_P/2) clk = ~clk;

  sreg_serial_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .sen_i(sen), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .ofs_o(ofs), .gain_o(gain), .pd_o(pd)
  );

  function automatic void model_reset();
    for (int i = 0; i < 3; i++) begin
      m_ofs[i] = 8'h80; m_msb[i] = 8'h0C; m_lsb[i] = 1'b0;
    end
    m_pd = '0;
  endfunction

  function automatic void model_write(input logic [5:0] a, input logic [7:0] d);
    for (int i = 0; i < 3; i++) begin
      if (a == 6'h20 + 6'(i) || a == 6'h23) m_ofs[i] = d;
      if (a == 6'h24 + 6'(i) || a == 6'h27) m_lsb[i] = d[0];
      if (a == 6'h28 + 6'(i) || a == 6'h2B) m_msb[i] = d;
    end
    if (a == 6'h07) m_pd = d[6:0];
  endfunction

  function automatic logic [7:0] model_read(input logic [5:0] a);
    for (int i = 0; i < 3; i++) begin
      if (a == 6'h20 + 6'(i)) return m_ofs[i];
      if (a == 6'h24 + 6'(i)) return {7'b0, m_lsb[i]};
      if (a == 6'h28 + 6'(i)) return m_msb[i];
    end
    if (a == 6'h07) return {1'b0, m_pd};
    return 8'h00;
  endfunction

  function automatic logic [23:0] exp_ofs();
    return {m_ofs[2], m_ofs[1], m_ofs[0]};
  endfunction

  function automatic logic [26:0] exp_gain();
    return {m_msb[2], m_lsb[2], m_msb[1], m_lsb[1], m_msb[0], m_lsb[0]};
  endfunction

  // commit of a write lands two clocks after the enable falls
  always @(posedge clk) begin
    if (pend_cnt > 0) begin
      pend_cnt = pend_cnt - 1;
      if (pend_cnt == 0) model_write(pend_a, pend_d);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (ofs !== exp_ofs() || gain !== exp_gain() || pd !== {m_pd}) begin
        bad++;
        $display("FAIL R2/R3/R4/R5/R6 per-clock ofs=%h/%h gain=%h/%h pd=%h/%h (act/exp)",
                 ofs, exp_ofs(), gain, exp_gain(), pd, m_pd);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit rw, input logic [5:0] a, input logic [7:0] d,
                       input int nbits, output logic [7:0] rd);
    logic [14:0] v;
    v  = {rw, a, d};
    rd = '0;
    @(negedge clk); sen = 1'b1;
    wait_clk(3);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 15) ? v[14-i] : 1'b0;
      wait_clk(2);
      if (i >= 7 && i <= 14) rd[14-i] = sdo;
      else if (rw) chk("R9 sdo idle outside data phase", {31'b0, sdo}, 32'h0);
      sck = 1'b1;
      wait_clk(2);
      sck = 1'b0;
    end
    wait_clk(2);
    sen = 1'b0;
    if (nbits == 15 && !rw) begin
      pend_a = a; pend_d = d; pend_cnt = 2;
    end
    wait_clk(4);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    frame(1'b0, a, d, 15, dummy);
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a);
    logic [7:0] r;
    frame(1'b1, a, 8'h00, 15, r);
    chk(req, {24'b0, r}, {24'b0, model_read(a)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk;
    model_reset();
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R1 reset offsets", {8'h0, ofs}, {8'h0, 24'h808080});
    chk("R1 reset gains", {5'h0, gain}, {5'h0, 9'h018, 9'h018, 9'h018});
    chk("R1 reset pd", {25'h0, pd}, 32'h0);

    wr(6'h21, 8'h5A);                              // R2 R7
    chk("R2 green offset only", {8'h0, ofs}, {8'h0, 24'h805A80});
    rd_chk("R9 read green offset", 6'h21);
    rd_chk("R9 read red offset untouched", 6'h20);

    wr(6'h23, 8'hC3);                              // R3
    chk("R3 broadcast offsets", {8'h0, ofs}, {8'h0, 24'hC3C3C3});
    rd_chk("R10 offset broadcast reads zero", 6'h23);

    wr(6'h25, 8'hFF);                              // R4
    rd_chk("R10 gain LSB reserved bits zero", 6'h25);
    wr(6'h29, 8'hA5);
    chk("R4 green gain assembled", {23'h0, gain[17:9]}, {23'h0, 9'h14B});
    chk("R4 red gain untouched", {23'h0, gain[8:0]}, {23'h0, 9'h018});

    wr(6'h27, 8'h01);                              // R5
    wr(6'h2B, 8'h3C);
    chk("R5 broadcast gains", {5'h0, gain}, {5'h0, 9'h079, 9'h079, 9'h079});
    rd_chk("R10 gain MSB broadcast reads zero", 6'h2B);
    rd_chk("R10 gain LSB broadcast reads zero", 6'h27);
    wr(6'h24, 8'hFE);
    chk("R4 LSB write takes bit0 only", {23'h0, gain[8:0]}, {23'h0, 9'h078});

    wr(6'h07, 8'hFF);                              // R6
    chk("R6 pd bits", {25'h0, pd}, {25'h0, 7'h7F});
    rd_chk("R6 pd read bit7 zero", 6'h07);
    wr(6'h07, 8'h2A);
    rd_chk("R6 pd read pattern", 6'h07);

    frame(1'b0, 6'h20, 8'h11, 14, junk);           // R8 short
    chk("R8 short frame ignored", {24'h0, ofs[7:0]}, 32'hC3);
    frame(1'b0, 6'h20, 8'h11, 16, junk);           // R8 long
    chk("R8 long frame ignored", {24'h0, ofs[7:0]}, 32'hC3);
    for (int i = 0; i < 20; i++) begin             // R8 clocks with enable low
      sdi = i[0]; sck = 1'b1; wait_clk(2); sck = 1'b0; wait_clk(2);
    end
    chk("R8 sck without enable ignored", {8'h0, ofs}, {8'h0, 24'hC3C3C3});
    rd_chk("R7 red offset after bad frames", 6'h20);

    rd_chk("R10 unmapped reads zero", 6'h3F);
    rd_chk("R9 read blue gain MSB", 6'h2A);
    wr(6'h22, 8'h01);
    rd_chk("R2 blue offset", 6'h22);

    wait_clk(4);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule